// File: doc/BRIEF.md
# Inbound Command Deserializer

This block turns commands that arrive from the system side one 15-bit slice per clock into a single decoded record. The bus is active-low, so every slice is inverted before any field is read. A command begins on a clock where `cmd_start` is high while the block is idle. Bit 14 of that first slice, after inversion, sets the command's length. A value of 1 marks a probe that runs for four slices. A value of 0 marks a data-movement command that runs for two slices. The slices that follow arrive on consecutive clocks.

A probe carries a probe code, a 43-bit physical address that is spread over all four slices, a data-movement code, three response flags, a 4-bit transaction ID and a tail flag. A data-movement command carries only the code, the flags, the ID and the tail flag. Its two slices use the same layout as probe slices three and four. Bus lines 1:0 carry the high address bits 42:35. These lines are optional: the `EXT_LINES` parameter turns them off, and the high address bits then read as zero.

The sequencer has five named states. `ST_IDLE` waits for a start. Probes walk `ST_PRB2` → `ST_PRB3` → `ST_PRB4` → `ST_IDLE`, one slice per state. Data-movement commands go `ST_DM2` → `ST_IDLE`. The transitions out of `ST_IDLE` are *start-probe* (to `ST_PRB2`), *start-data* (to `ST_DM2`) and *stay* (no start). Every other state has exactly one unconditional transition.

Top module: `inbound_cmd_deser`

## Requirements
- R1: While reset is asserted and on the first clock after it, `rec_valid` is 0, every record output is 0 and the sequencer is in `ST_IDLE`.
- R2: In idle, a start slice whose inverted bit 14 is 1 opens a probe. The record appears with `rec_valid`=1 and `rec_is_probe`=1 on the first clock edge after the fourth slice is sampled.
- R3: A start slice whose inverted bit 14 is 0 opens a data-movement command. Its record appears after the second slice with `rec_is_probe`=0, `rec_addr`=0 and `rec_probe_code`=0. Bits 13:0 of its second slice and bits 1:0 of its first slice have no effect.
- R4: Each slice is used inverted. In probe slice 1, bits 13:9 are the probe code and bits 8:2 are address 34:28. In slice 2, bits 14:9 are address 27:22 and bits 8:2 are address 12:6. In slice 4, bits 13:5 are address 21:13 and bits 4:2 are address 5:3.
- R5: In the code slice (probe slice 3, data slice 1), bits 13:9 are the data-movement code, bits 8, 7 and 6 are `rec_flags[2]`, `[1]` and `[0]`, and bits 5:2 are the ID. In the final slice (probe slice 4, data slice 2), bit 14 is `rec_tail_flag`.
- R6: With `EXT_LINES`=1, probe bits 1 and 0 carry address bits 36/38 in slice 1, 35/37 in slice 2, 40/42 in slice 3 and 39/41 in slice 4.
- R7: With `EXT_LINES`=0, `rec_addr[42:35]` is always 0.
- R8: `rec_addr[2:0]` is always 0.
- R9: A new start on the clock right after a command's final slice is accepted, so commands can follow one another with no gap.
- R10: `cmd_start` has no effect on slices 2 to 4 of a command in progress. While idle, a slice without `cmd_start` produces no record.
- R11: `rec_valid` is a one-cycle pulse. The record outputs keep their value until the next command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Marks the first slice of a command |
| cmd_bus_n | input | 15 | Active-low command slice |
| rec_valid | output | 1 | One-cycle pulse: record is new |
| rec_is_probe | output | 1 | Record came from a probe |
| rec_probe_code | output | 5 | Probe code |
| rec_addr | output | 43 | Assembled physical address |
| rec_dm_code | output | 5 | Data-movement code |
| rec_flags | output | 3 | Response flags |
| rec_id | output | 4 | Transaction ID |
| rec_tail_flag | output | 1 | Flag from the final slice |

## Verification
Each record is due on the first rising edge after its final slice is sampled. That is four slices after a probe's start and two after a data command's start. The bench drives every slice on a falling edge. On the following falling edge, before it drives the next slice, it checks the outputs. So the record of a command shows up exactly one tick after that command's last slice, even when the next command's first slice is being driven on that same tick. On every other tick `rec_valid` must be low. A second instance with the optional lines turned off is checked against the same stimulus, with address bits 42:35 expected to read as zero.

// File: rtl/icd_pkg.sv
package icd_pkg;
    localparam int BUS_W   = 15;
    localparam int ADDR_W  = 43;
    localparam int CODE_W  = 5;
    localparam int FLAG_W  = 3;
    localparam int ID_W    = 4;
    localparam int TYPE_BIT = BUS_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRB2, ST_PRB3, ST_PRB4, ST_DM2
    } icd_state_e;

    typedef enum logic [2:0] {
        SL_NONE, SL_P1, SL_P2, SL_P3, SL_P4, SL_D1, SL_D2
    } slice_e;

    typedef struct packed {
        logic              is_probe;
        logic [CODE_W-1:0] probe_code;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] dm_code;
        logic [FLAG_W-1:0] flags;
        logic [ID_W-1:0]   id;
        logic              tail;
    } cmd_rec_t;
endpackage

// File: rtl/icd_bus_in.sv
module icd_bus_in
    import icd_pkg::*;
(
    input  logic [BUS_W-1:0] bus_n,
    output logic [BUS_W-1:0] slice_d,
    output logic             type_bit
);
    assign slice_d  = ~bus_n;
    assign type_bit = slice_d[TYPE_BIT];
endmodule

// File: rtl/icd_seq_fsm.sv
module icd_seq_fsm
    import icd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       type_bit,
    output slice_e     slice,
    output logic       last,
    output icd_state_e state
);
    icd_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = type_bit ? ST_PRB2 : ST_DM2;
            ST_PRB2: nxt = ST_PRB3;
            ST_PRB3: nxt = ST_PRB4;
            ST_PRB4: nxt = ST_IDLE;
            ST_DM2:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        slice = SL_NONE;
        last  = 1'b0;
        unique case (state)
            ST_IDLE: if (start) slice = type_bit ? SL_P1 : SL_D1;
            ST_PRB2: slice = SL_P2;
            ST_PRB3: slice = SL_P3;
            ST_PRB4: begin slice = SL_P4; last = 1'b1; end
            ST_DM2:  begin slice = SL_D2; last = 1'b1; end
            default: slice = SL_NONE;
        endcase
    end

    p_prb2_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PRB2 |=> state == ST_PRB3);
    p_prb3_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PRB3 |=> state == ST_PRB4);
    p_prb4_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PRB4 |=> state != ST_PRB3 && state != ST_PRB4);
    p_dm_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DM2 |=> state != ST_PRB3 && state != ST_PRB4 && state != ST_DM2);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && !start |=> state == ST_IDLE);
endmodule

// File: rtl/icd_field_asm.sv
module icd_field_asm
    import icd_pkg::*;
#(
    parameter bit EXT_LINES = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  slice_e           slice,
    input  logic             last,
    input  logic [BUS_W-1:0] d,
    output cmd_rec_t         rec,
    output logic             rec_valid
);
    cmd_rec_t work, nxt_work;
    logic [1:0] lo;

    generate
        if (EXT_LINES) begin : g_ext
            assign lo = d[1:0];
        end else begin : g_noext
            assign lo = 2'b00;
        end
    endgenerate

    always_comb begin
        nxt_work = work;
        unique case (slice)
            SL_P1: begin
                nxt_work            = '0;
                nxt_work.is_probe   = 1'b1;
                nxt_work.probe_code = d[13:9];
                nxt_work.addr[34:28] = d[8:2];
                nxt_work.addr[36]   = lo[1];
                nxt_work.addr[38]   = lo[0];
            end
            SL_P2: begin
                nxt_work.addr[27:22] = d[14:9];
                nxt_work.addr[12:6]  = d[8:2];
                nxt_work.addr[35]    = lo[1];
                nxt_work.addr[37]    = lo[0];
            end
            SL_P3: begin
                nxt_work.dm_code  = d[13:9];
                nxt_work.flags    = d[8:6];
                nxt_work.id       = d[5:2];
                nxt_work.addr[40] = lo[1];
                nxt_work.addr[42] = lo[0];
            end
            SL_P4: begin
                nxt_work.tail        = d[14];
                nxt_work.addr[21:13] = d[13:5];
                nxt_work.addr[5:3]   = d[4:2];
                nxt_work.addr[39]    = lo[1];
                nxt_work.addr[41]    = lo[0];
            end
            SL_D1: begin
                nxt_work         = '0;
                nxt_work.dm_code = d[13:9];
                nxt_work.flags   = d[8:6];
                nxt_work.id      = d[5:2];
            end
            SL_D2:   nxt_work.tail = d[14];
            default: nxt_work = work;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work      <= '0;
            rec       <= '0;
            rec_valid <= 1'b0;
        end else begin
            work      <= nxt_work;
            rec_valid <= last;
            if (last) rec <= nxt_work;
        end
    end

    p_addr_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> rec.addr[2:0] == 3'b000);
    p_dm_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec.is_probe |-> rec.addr == '0 && rec.probe_code == '0);
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |-> $stable(rec));

    generate
        if (!EXT_LINES) begin : g_chk_noext
            p_noext_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
                rec.addr[42:35] == 8'h00);
        end
    endgenerate
endmodule

// File: rtl/inbound_cmd_deser.sv
module inbound_cmd_deser
    import icd_pkg::*;
#(
    parameter bit EXT_LINES = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [14:0] cmd_bus_n,
    output logic        rec_valid,
    output logic        rec_is_probe,
    output logic [4:0]  rec_probe_code,
    output logic [42:0] rec_addr,
    output logic [4:0]  rec_dm_code,
    output logic [2:0]  rec_flags,
    output logic [3:0]  rec_id,
    output logic        rec_tail_flag
);
    logic [BUS_W-1:0] slice_d;
    logic             type_bit;
    slice_e           slice;
    logic             last;
    icd_state_e       state;
    cmd_rec_t         rec;

    icd_bus_in u_in (
        .bus_n    (cmd_bus_n),
        .slice_d  (slice_d),
        .type_bit (type_bit)
    );

    icd_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_start),
        .type_bit (type_bit),
        .slice    (slice),
        .last     (last),
        .state    (state)
    );

    icd_field_asm #(.EXT_LINES(EXT_LINES)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slice     (slice),
        .last      (last),
        .d         (slice_d),
        .rec       (rec),
        .rec_valid (rec_valid)
    );

    assign rec_is_probe   = rec.is_probe;
    assign rec_probe_code = rec.probe_code;
    assign rec_addr       = rec.addr;
    assign rec_dm_code    = rec.dm_code;
    assign rec_flags      = rec.flags;
    assign rec_id         = rec.id;
    assign rec_tail_flag  = rec.tail;

    p_valid_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> rec_valid);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> state == ST_IDLE && !rec_valid);
endmodule

// File: tb/tb_inbound_cmd_deser.sv
`timescale 1ns/1ps
module tb_inbound_cmd_deser;
    import icd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [14:0] cmd_bus_n = '1;

    logic        v_a, p_a, v_b, p_b, t_a, t_b;
    logic [4:0]  pc_a, dm_a, pc_b, dm_b;
    logic [42:0] ad_a, ad_b;
    logic [2:0]  fl_a, fl_b;
    logic [3:0]  id_a, id_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit       pend = 1'b0;
    cmd_rec_t pend_exp;
    string    pend_tag;

    always #10 clk = ~clk;

    inbound_cmd_deser #(.EXT_LINES(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_bus_n(cmd_bus_n),
        .rec_valid(v_a), .rec_is_probe(p_a), .rec_probe_code(pc_a), .rec_addr(ad_a),
        .rec_dm_code(dm_a), .rec_flags(fl_a), .rec_id(id_a), .rec_tail_flag(t_a));

    inbound_cmd_deser #(.EXT_LINES(1'b0)) dut_noext (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_bus_n(cmd_bus_n),
        .rec_valid(v_b), .rec_is_probe(p_b), .rec_probe_code(pc_b), .rec_addr(ad_b),
        .rec_dm_code(dm_b), .rec_flags(fl_b), .rec_id(id_b), .rec_tail_flag(t_b));

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic cmd_rec_t got_a();
        cmd_rec_t r;
        r.is_probe = p_a; r.probe_code = pc_a; r.addr = ad_a; r.dm_code = dm_a;
        r.flags = fl_a; r.id = id_a; r.tail = t_a;
        return r;
    endfunction

    function automatic cmd_rec_t got_b();
        cmd_rec_t r;
        r.is_probe = p_b; r.probe_code = pc_b; r.addr = ad_b; r.dm_code = dm_b;
        r.flags = fl_b; r.id = id_b; r.tail = t_b;
        return r;
    endfunction

    function automatic cmd_rec_t strip_ext(input cmd_rec_t e);
        cmd_rec_t r = e;
        r.addr[42:35] = 8'h00;
        return r;
    endfunction

    // Builds the true-polarity probe slices from the slice layouts of R4, R5 and R6.
    function automatic logic [3:0][14:0] probe_slices(input cmd_rec_t e);
        logic [3:0][14:0] s;
        s[0] = {1'b1, e.probe_code, e.addr[34:28], e.addr[36], e.addr[38]};
        s[1] = {e.addr[27:22], e.addr[12:6], e.addr[35], e.addr[37]};
        s[2] = {1'b0, e.dm_code, e.flags, e.id, e.addr[40], e.addr[42]};
        s[3] = {e.tail, e.addr[21:13], e.addr[5:3], e.addr[39], e.addr[41]};
        return s;
    endfunction

    // Data command: code slice then tail slice; unused bits carry junk (R3).
    function automatic logic [3:0][14:0] dm_slices(input cmd_rec_t e, input logic [15:0] junk);
        logic [3:0][14:0] s;
        s[0] = {1'b0, e.dm_code, e.flags, e.id, junk[15:14]};
        s[1] = {e.tail, junk[13:0]};
        s[2] = '0;
        s[3] = '0;
        return s;
    endfunction

    task automatic tick();
        @(negedge clk);
        if (pend) begin
            chk(v_a == 1'b1, pend_tag, "valid", 64'(v_a), 64'd1);
            chk(got_a() == pend_exp, pend_tag, "record", 64'(got_a().addr), 64'(pend_exp.addr));
            chk(got_a().is_probe == pend_exp.is_probe && got_a().dm_code == pend_exp.dm_code
                && got_a().flags == pend_exp.flags && got_a().id == pend_exp.id
                && got_a().tail == pend_exp.tail && got_a().probe_code == pend_exp.probe_code,
                "R5", "fields", 64'(got_a()), 64'(pend_exp));
            chk(v_b == 1'b1 && got_b() == strip_ext(pend_exp), "R7", "noext record",
                64'(got_b().addr), 64'(strip_ext(pend_exp).addr));
            pend = 1'b0;
        end else begin
            chk(v_a == 1'b0 && v_b == 1'b0, "R10", "idle valid", 64'({v_a, v_b}), 64'd0);
        end
    endtask

    task automatic send(input logic [3:0][14:0] s, input int n, input bit stray,
                        input cmd_rec_t e, input string tag);
        for (int i = 0; i < n; i++) begin
            tick();
            cmd_start = (i == 0) ? 1'b1 : stray;
            cmd_bus_n = ~s[i];
        end
        pend_exp = e;
        pend_tag = tag;
        pend     = 1'b1;
    endtask

    task automatic idle_slice();
        tick();
        cmd_start = 1'b0;
        cmd_bus_n = 15'($urandom);
    endtask

    function automatic cmd_rec_t rand_probe();
        cmd_rec_t e;
        e.is_probe   = 1'b1;
        e.probe_code = 5'($urandom);
        e.addr       = {11'($urandom), 32'($urandom)};
        e.addr[2:0]  = 3'b000;
        e.dm_code    = 5'($urandom);
        e.flags      = 3'($urandom);
        e.id         = 4'($urandom);
        e.tail       = 1'($urandom);
        return e;
    endfunction

    function automatic cmd_rec_t rand_dm();
        cmd_rec_t e = '0;
        e.dm_code = 5'($urandom);
        e.flags   = 3'($urandom);
        e.id      = 4'($urandom);
        e.tail    = 1'($urandom);
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        cmd_rec_t e;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        chk(v_a == 1'b0 && got_a() == '0 && v_b == 1'b0, "R1", "reset outputs",
            64'(got_a().addr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(v_a == 1'b0 && got_a() == '0, "R1", "after reset", 64'(got_a().addr), 64'd0);

        // R10: junk slices in idle without a start make no record
        for (int i = 0; i < 6; i++) idle_slice();

        // R2/R4/R6: all fields set, then all clear
        e = '0; e.is_probe = 1'b1; e.probe_code = '1; e.addr = '1; e.addr[2:0] = 3'b000;
        e.dm_code = '1; e.flags = '1; e.id = '1; e.tail = 1'b1;
        send(probe_slices(e), 4, 1'b0, e, "R2");
        idle_slice();
        e = '0; e.is_probe = 1'b1;
        send(probe_slices(e), 4, 1'b0, e, "R4");
        idle_slice();

        // R6: a walking one through the high address bits
        for (int b = 35; b <= 42; b++) begin
            e = '0; e.is_probe = 1'b1; e.addr[b] = 1'b1;
            send(probe_slices(e), 4, 1'b0, e, "R6");
        end
        idle_slice();

        // R3: data command with junk in its unused bits; R9: back-to-back commands
        e = rand_dm();
        send(dm_slices(e, 16'hFFFF), 2, 1'b0, e, "R3");
        e = rand_dm();
        send(dm_slices(e, 16'h5A5A), 2, 1'b0, e, "R9");
        e = rand_probe();
        send(probe_slices(e), 4, 1'b0, e, "R9");
        e = rand_dm();
        send(dm_slices(e, 16'h0F0F), 2, 1'b0, e, "R9");

        // R10: a start held high through every slice of a probe
        e = rand_probe();
        send(probe_slices(e), 4, 1'b1, e, "R10");
        idle_slice();

        // R11: outputs hold their value over idle cycles
        e = rand_probe();
        send(probe_slices(e), 4, 1'b0, e, "R11");
        idle_slice();
        for (int i = 0; i < 3; i++) begin
            idle_slice();
            chk(got_a() == e, "R11", "hold", 64'(got_a().addr), 64'(e.addr));
        end

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 1) == 0) begin
                e = rand_probe();
                send(probe_slices(e), 4, 1'($urandom_range(0, 3) == 0), e, "R2");
            end else begin
                e = rand_dm();
                send(dm_slices(e, 16'($urandom)), 2, 1'($urandom_range(0, 3) == 0), e, "R3");
            end
            for (int g = $urandom_range(0, 2); g > 0; g--) idle_slice();
        end
        idle_slice();
        idle_slice();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule